// File: doc/BRIEF.md
# Single-Wire Bus Master with Polled Command Register

This block is a master for a single-wire, open-drain bus with a byte-wide register port. Software writes a command bit to start either a bus reset with presence detection or one time slot carrying one bit. It then polls the same register until the command bit clears, and reads the result from the status bits. A programmable prescaler divides the system clock down to a one-microsecond tick. Every phase of a sequence is a count of those ticks. The line is never driven high. The output `bus_pull` enables a pull-down, and `bus_in` samples the wired level.

There are three registers. The command/status register sits at offset 0x0 and the divider register at offset 0x2. The soft-reset register sits at offset 0x4; while its bit 0 is set, the block is held idle. One sequencer state machine moves through six named states. From `S_IDLE`, a reset command goes to `S_RST_LOW`, then `S_PRES_WIN`, then back to `S_IDLE`. A write-0 command goes through `S_SLOT_LOW` and `S_RECOV`, then back to `S_IDLE`. A write-1/read command goes through `S_SLOT_LOW`, `S_SLOT_REL` and `S_RECOV`, then back to `S_IDLE`. A soft reset forces `S_IDLE` from any state.

Top module: `onewire_master`

## Requirements
- R1: After `rst_n` is released, the command/status register reads 0x00, the divider reads 0x00 and `bus_pull` is 0.
- R2: The divider register at offset 0x2 holds N-1 and reads back as written. One timing tick lasts N clock cycles, and each tick count is restarted when a command is accepted.
- R3: Writing bit 7 of offset 0x0 starts a reset sequence. `bus_pull` is 1 for 511 ticks, then the line is released for a 512-tick window. Bit 7 reads 1 for exactly 1023 ticks from the accepting edge and then clears.
- R4: Bit 6 of offset 0x0 is the presence flag. It is set to 1 if `bus_in` is low, or to 0 if it is high, at the end of the 70th tick after the reset pull-down ends. It keeps that value until the next sample or a soft reset.
- R5: Writing bit 5 starts a write-0 slot: 60 ticks with `bus_pull` at 1, then 5 recovery ticks with the line released. Bit 5 reads 1 for the 65 ticks.
- R6: Writing bit 4 starts a write-1/read slot: 5 ticks pulled low, then release. `bus_in` is sampled into bit 3 at the end of tick 15 and the slot ends after tick 60. After 5 recovery ticks, bit 4 clears 65 ticks after the start.
- R7: A command write accepted while any sequence is busy has no effect on the running sequence, `bus_pull` or the status bits.
- R8: When a single write sets several command bits, only one starts, in this priority: reset (bit 7), then write-0 (bit 5), then write-1/read (bit 4).
- R9: While bit 0 of offset 0x4 is 1, `bus_pull` is 0 and the command/status register reads 0x00. Command writes are ignored and any running sequence is aborted. After the bit is cleared, the status bits read 0 and the divider keeps its value. Offset 0x4 reads back the bit in position 0.
- R10: A write to offset 0x0 with bits 7, 5 and 4 all clear starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset (0x0 command/status, 0x2 divider, 0x4 soft reset) |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| bus_pull | output | 1 | 1 enables the bus pull-down |
| bus_in | input | 1 | Sampled bus level |

## Verification
The embedded assertions check on every cycle that:
- at most one busy bit is set;
- soft reset releases the bus;
- the presence flag holds still outside a reset sequence;
- the microsecond counter stays in range;
- the tick never fires on two adjacent cycles when N exceeds one.

Only the bench's scenarios can show the exact tick counts of each phase, the sampling instants, command priority, the ignoring of writes while busy, and the divider surviving a soft reset. The bench shows these by comparing `bus_pull` and the register read data on every clock against its behavioural reference model.

// File: rtl/owm_pkg.sv
package owm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST_LOW,
        S_PRES_WIN,
        S_SLOT_LOW,
        S_SLOT_REL,
        S_RECOV
    } owm_state_e;

    typedef enum logic [1:0] {
        OP_RST,
        OP_W0,
        OP_W1
    } owm_op_e;

endpackage

// File: rtl/owm_prescaler.sv
module owm_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: with N above one, ticks are separated by idle cycles
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || div_i == '0));

endmodule

// File: rtl/owm_sequencer.sv
module owm_sequencer
    import owm_pkg::*;
#(
    parameter int T_RST_LOW  = 511,
    parameter int T_PRES_WIN = 512,
    parameter int T_PRES_SMP = 70,
    parameter int T_SLOT     = 60,
    parameter int T_W1_LOW   = 5,
    parameter int T_RD_SMP   = 15,
    parameter int T_RECOV    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic start_rst,
    input  logic start_w0,
    input  logic start_w1,
    input  logic bus_in,
    output logic idle,
    output logic bus_pull,
    output logic busy_rst,
    output logic busy_w0,
    output logic busy_w1,
    output logic presence,
    output logic rd_bit
);
    localparam int MAX_T = (T_PRES_WIN > T_RST_LOW) ? T_PRES_WIN : T_RST_LOW;
    localparam int US_W  = $clog2(MAX_T + 1);
    localparam logic [US_W-1:0] RST_LAST  = US_W'(T_RST_LOW - 1);
    localparam logic [US_W-1:0] WIN_LAST  = US_W'(T_PRES_WIN - 1);
    localparam logic [US_W-1:0] PRES_AT   = US_W'(T_PRES_SMP - 1);
    localparam logic [US_W-1:0] SLOT_LAST = US_W'(T_SLOT - 1);
    localparam logic [US_W-1:0] W1_LAST   = US_W'(T_W1_LOW - 1);
    localparam logic [US_W-1:0] RD_AT     = US_W'(T_RD_SMP - 1);
    localparam logic [US_W-1:0] REC_LAST  = US_W'(T_RECOV - 1);

    owm_state_e      st_q, st_n;
    owm_op_e         op_q, op_n;
    logic [US_W-1:0] us_q, us_n;
    logic            pres_q, pres_n, rd_q, rd_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            op_q   <= OP_RST;
            us_q   <= '0;
            pres_q <= 1'b0;
            rd_q   <= 1'b0;
        end else begin
            st_q   <= st_n;
            op_q   <= op_n;
            us_q   <= us_n;
            pres_q <= pres_n;
            rd_q   <= rd_n;
        end
    end

    // next-state and sampling
    always_comb begin
        st_n   = st_q;
        op_n   = op_q;
        us_n   = us_q;
        pres_n = pres_q;
        rd_n   = rd_q;
        unique case (st_q)
            S_IDLE: begin
                us_n = '0;
                if (start_rst) begin
                    st_n = S_RST_LOW;
                    op_n = OP_RST;
                end else if (start_w0) begin
                    st_n = S_SLOT_LOW;
                    op_n = OP_W0;
                end else if (start_w1) begin
                    st_n = S_SLOT_LOW;
                    op_n = OP_W1;
                end
            end
            S_RST_LOW: if (tick) begin
                if (us_q == RST_LAST) begin
                    st_n = S_PRES_WIN;
                    us_n = '0;
                end else
                    us_n = us_q + 1'b1;
            end
            S_PRES_WIN: if (tick) begin
                if (us_q == PRES_AT)
                    pres_n = ~bus_in;
                if (us_q == WIN_LAST) begin
                    st_n = S_IDLE;
                    us_n = '0;
                end else
                    us_n = us_q + 1'b1;
            end
            S_SLOT_LOW: if (tick) begin
                if (op_q == OP_W0 && us_q == SLOT_LAST) begin
                    st_n = S_RECOV;
                    us_n = '0;
                end else begin
                    if (op_q != OP_W0 && us_q == W1_LAST)
                        st_n = S_SLOT_REL;
                    us_n = us_q + 1'b1;
                end
            end
            S_SLOT_REL: if (tick) begin
                if (us_q == RD_AT)
                    rd_n = bus_in;
                if (us_q == SLOT_LAST) begin
                    st_n = S_RECOV;
                    us_n = '0;
                end else
                    us_n = us_q + 1'b1;
            end
            S_RECOV: if (tick) begin
                if (us_q == REC_LAST) begin
                    st_n = S_IDLE;
                    us_n = '0;
                end else
                    us_n = us_q + 1'b1;
            end
            default: st_n = S_IDLE;
        endcase
        if (clr) begin
            st_n   = S_IDLE;
            op_n   = OP_RST;
            us_n   = '0;
            pres_n = 1'b0;
            rd_n   = 1'b0;
        end
    end

    // outputs
    always_comb begin
        idle     = (st_q == S_IDLE);
        bus_pull = ~clr & ((st_q == S_RST_LOW) || (st_q == S_SLOT_LOW));
        busy_rst = (st_q == S_RST_LOW) || (st_q == S_PRES_WIN);
        busy_w0  = !idle && !busy_rst && (op_q == OP_W0);
        busy_w1  = !idle && !busy_rst && (op_q == OP_W1);
        presence = pres_q;
        rd_bit   = rd_q;
    end

    // R4: presence holds still outside reset sequences and soft reset
    a_r4_presence_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_rst && !$past(busy_rst) && !clr && !$past(clr)) |-> $stable(pres_q));

    // R3: phase counter never passes the longest phase
    a_r3_counter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        us_q <= US_W'(MAX_T));

endmodule

// File: rtl/onewire_master.sv
module onewire_master
    import owm_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int T_RST_LOW  = 511,
    parameter int T_PRES_WIN = 512,
    parameter int T_PRES_SMP = 70,
    parameter int T_SLOT     = 60,
    parameter int T_W1_LOW   = 5,
    parameter int T_RD_SMP   = 15,
    parameter int T_RECOV    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       bus_pull,
    input  logic       bus_in
);
    localparam logic [2:0] A_CTRL = 3'h0;
    localparam logic [2:0] A_DIV  = 3'h2;
    localparam logic [2:0] A_SRST = 3'h4;

    logic [DIV_W-1:0] div_q;
    logic             srst_q;
    logic             ctl_wr, st_rst, st_w0, st_w1, pre_clr, tick, idle;
    logic             busy_rst, busy_w0, busy_w1, presence, rd_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            srst_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_DIV)
                div_q <= DIV_W'(wdata);
            if (addr == A_SRST)
                srst_q <= wdata[0];
        end
    end

    always_comb begin
        ctl_wr  = wr_en && (addr == A_CTRL) && !srst_q;
        st_rst  = ctl_wr && wdata[7];
        st_w0   = ctl_wr && !wdata[7] && wdata[5];
        st_w1   = ctl_wr && !wdata[7] && !wdata[5] && wdata[4];
        pre_clr = srst_q || (idle && (st_rst || st_w0 || st_w1));
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = srst_q ? 8'h00 :
                             {busy_rst, presence, busy_w0, busy_w1, rd_bit, 3'b000};
            A_DIV:   rdata = 8'(div_q);
            A_SRST:  rdata = {7'b0, srst_q};
            default: rdata = 8'h00;
        endcase
    end

    owm_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .div_i (div_q),
        .tick  (tick)
    );

    owm_sequencer #(
        .T_RST_LOW (T_RST_LOW), .T_PRES_WIN(T_PRES_WIN), .T_PRES_SMP(T_PRES_SMP),
        .T_SLOT    (T_SLOT),    .T_W1_LOW  (T_W1_LOW),   .T_RD_SMP  (T_RD_SMP),
        .T_RECOV   (T_RECOV)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst_q),
        .tick      (tick),
        .start_rst (st_rst),
        .start_w0  (st_w0),
        .start_w1  (st_w1),
        .bus_in    (bus_in),
        .idle      (idle),
        .bus_pull  (bus_pull),
        .busy_rst  (busy_rst),
        .busy_w0   (busy_w0),
        .busy_w1   (busy_w1),
        .presence  (presence),
        .rd_bit    (rd_bit)
    );

    // R8: a single sequence runs at a time
    a_r8_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_rst, busy_w0, busy_w1}));

    // R9: soft reset keeps the bus released
    a_r9_srst_release: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |-> !bus_pull);

    // R7: a command write while busy starts nothing new
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w1 && ctl_wr) |=> !busy_rst);

endmodule

// File: tb/onewire_master_tb.sv
module onewire_master_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       bus_pull;
    logic       bus_in;
    logic       dev_low = 1'b0;

    int checks = 0;
    int fails = 0;
    int fail_prints = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    assign bus_in = !(bus_pull || dev_low);

    always #5 clk = ~clk;

    onewire_master u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .bus_pull(bus_pull), .bus_in(bus_in)
    );

    // behavioural reference model
    int  m_div = 0;
    bit  m_srst = 0;
    bit  m_act = 0;
    int  m_op = 0;      // 0 reset, 1 write-0, 2 write-1/read
    int  m_el = 0;
    int  m_n = 1;
    bit  m_pres = 0;
    bit  m_rd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div <= 0; m_srst <= 0; m_act <= 0; m_el <= 0; m_pres <= 0; m_rd <= 0;
        end else begin
            if (m_act) begin
                if (m_op == 0 && m_el + 1 == 581 * m_n) m_pres <= dev_low;
                if (m_op == 2 && m_el + 1 == 15 * m_n)  m_rd <= !dev_low;
                if (m_el + 1 == ((m_op == 0) ? 1023 : 65) * m_n) m_act <= 0;
                m_el <= m_el + 1;
            end
            if (wr_en) begin
                if (addr == 3'd0 && !m_srst && !m_act &&
                    (wdata[7] || wdata[5] || wdata[4])) begin
                    m_act <= 1; m_el <= 0; m_n <= m_div + 1;
                    m_op  <= wdata[7] ? 0 : (wdata[5] ? 1 : 2);
                end
                if (addr == 3'd2) m_div <= wdata;
                if (addr == 3'd4) m_srst <= wdata[0];
            end
            if (m_srst) begin
                m_act <= 0; m_pres <= 0; m_rd <= 0;
            end
        end
    end

    function automatic bit exp_pull();
        int low;
        low = (m_op == 0) ? 511 : ((m_op == 1) ? 60 : 5);
        return !m_srst && m_act && (m_el < low * m_n);
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (addr == 3'd0)
            return m_srst ? 8'h00 : {m_act && m_op == 0, m_pres, m_act && m_op == 1,
                                     m_act && m_op == 2, m_rd, 3'b000};
        if (addr == 3'd2) return 8'(m_div);
        if (addr == 3'd4) return {7'b0, m_srst};
        return 8'h00;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            if (fail_prints < 30) begin
                fail_prints++;
                $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
            end
        end
    endtask

    // per-cycle comparison, away from both clock edges
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check(bus_pull == exp_pull(), cur_req, "bus_pull vs model",
                  int'(bus_pull), int'(exp_pull()));
            check(rdata == exp_rdata(), cur_req, "rdata vs model",
                  int'(rdata), int'(exp_rdata()));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        addr = 3'd0;
    endtask

    // issue a command, then count busy cycles and pulled-low cycles
    task automatic run_op(input logic [7:0] cmd, input logic [7:0] busy_mask,
                          output int total, output int low);
        @(negedge clk);
        addr = 3'd0; wdata = cmd; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        total = 0; low = 0;
        #1;
        while ((rdata & busy_mask) != 8'h00 && total < 5000) begin
            total++;
            if (bus_pull) low++;
            @(negedge clk); #1;
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int tot, low;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cur_req = "R1";
        rd(3'd0, v); check(v == 8'h00, "R1", "control after reset", v, 0);
        rd(3'd2, v); check(v == 8'h00, "R1", "divider after reset", v, 0);
        check(bus_pull == 1'b0, "R1", "bus released", bus_pull, 0);

        // R5 write-0 with N=1
        cur_req = "R5";
        run_op(8'h20, 8'h20, tot, low);
        check(tot == 65, "R5", "write-0 busy cycles N=1", tot, 65);
        check(low == 60, "R5", "write-0 low cycles N=1", low, 60);

        // R2 divider N=2
        cur_req = "R2";
        wr(3'd2, 8'd1);
        rd(3'd2, v); check(v == 8'd1, "R2", "divider readback", v, 1);
        run_op(8'h20, 8'h20, tot, low);
        check(tot == 130, "R2", "write-0 busy cycles N=2", tot, 130);
        check(low == 120, "R2", "write-0 low cycles N=2", low, 120);

        // R3 / R4 reset with device answering
        cur_req = "R3";
        dev_low = 1'b1;
        run_op(8'h80, 8'h80, tot, low);
        check(tot == 2046, "R3", "reset busy cycles", tot, 2046);
        check(low == 1022, "R3", "reset low cycles", low, 1022);
        rd(3'd0, v); check(v[6] == 1'b1, "R4", "presence with device", v[6], 1);
        cur_req = "R4";
        dev_low = 1'b0;
        run_op(8'h80, 8'h80, tot, low);
        rd(3'd0, v); check(v[6] == 1'b0, "R4", "presence without device", v[6], 0);

        // R6 write-1/read
        cur_req = "R6";
        run_op(8'h10, 8'h10, tot, low);
        check(tot == 130, "R6", "read slot busy cycles", tot, 130);
        check(low == 10, "R6", "read slot low cycles", low, 10);
        rd(3'd0, v); check(v[3] == 1'b1, "R6", "read bit released line", v[3], 1);
        dev_low = 1'b1;
        run_op(8'h10, 8'h10, tot, low);
        rd(3'd0, v); check(v[3] == 1'b0, "R6", "read bit held line", v[3], 0);
        dev_low = 1'b0;

        // R7 writes while busy are ignored
        cur_req = "R7";
        wr(3'd0, 8'h10);
        wr(3'd0, 8'h80);
        rd(3'd0, v); check(v[7] == 1'b0 && v[4] == 1'b1, "R7", "busy write ignored", v, 8'h10);
        repeat (140) @(negedge clk);
        rd(3'd0, v); check(v[7:4] == 4'h0, "R7", "no late reset", v[7:4], 0);

        // R8 priority
        cur_req = "R8";
        wr(3'd0, 8'hB0);
        rd(3'd0, v); check(v[7:4] == 4'h8, "R8", "reset wins", v[7:4], 8);
        repeat (2100) @(negedge clk);
        wr(3'd0, 8'h30);
        rd(3'd0, v); check(v[7:4] == 4'h2, "R8", "write-0 over write-1", v[7:4], 2);
        repeat (140) @(negedge clk);

        // R10 no command bits
        cur_req = "R10";
        wr(3'd0, 8'h4F);
        rd(3'd0, v); check(v[7:4] == 4'h0, "R10", "no start", v[7:4], 0);
        check(bus_pull == 1'b0, "R10", "bus idle", bus_pull, 0);

        // R9 soft reset mid sequence
        cur_req = "R9";
        dev_low = 1'b1;
        run_op(8'h80, 8'h80, tot, low);
        wr(3'd0, 8'h80);
        repeat (20) @(negedge clk);
        wr(3'd4, 8'h01);
        check(bus_pull == 1'b0, "R9", "bus released in soft reset", bus_pull, 0);
        rd(3'd0, v); check(v == 8'h00, "R9", "control reads zero", v, 0);
        rd(3'd4, v); check(v == 8'h01, "R9", "soft reset readback", v, 1);
        wr(3'd0, 8'h20);
        wr(3'd4, 8'h00);
        rd(3'd0, v); check(v == 8'h00, "R9", "status cleared after", v, 0);
        rd(3'd2, v); check(v == 8'd1, "R9", "divider kept", v, 1);
        dev_low = 1'b0;
        repeat (5) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule